// File: doc/BRIEF.md
# Controller Command and Interrupt Register

This block is the primary command and status word of a network controller, together with the interrupt logic behind it. The host uses one 16-bit word to issue commands: begin initialisation, start, stop and transmit demand. The same word loads the interrupt enable. The upper half of the word holds sticky event flags. The receive, transmit, memory and timing logic raise these flags through single-cycle event inputs, and the host acknowledges them by writing ones to their positions. The block drives one interrupt line. It also reports its running state through a transmit-on and a receive-on enable and through one-cycle request pulses to the initialisation engine and the transmit poller.

A second, small register holds one mask bit. This bit keeps the init-done event from raising the interrupt, but the event still shows when the host polls. The host selects the register with `reg_sel`. Both registers are read combinationally on `rd_data`. The block has no streaming data path, so every pin is a plain control or status signal with no handshake.

Top module: `ctrl_cmd_irq`

## Requirements
- R1: After reset the command word (`reg_sel`=0) reads 0x0004, meaning stopped. The mask register reads 0. `irq`, `tx_on`, `rx_on`, `init_req` and `tx_demand` are all 0.
- R2: A command write with bit 1 (start) set and bit 2 clear sets `tx_on` and `rx_on` from the next cycle. After that write, bit 1 reads 1, bit 4 and bit 5 read 1, and bit 2 reads 0.
- R3: A command write with bit 0 (init) set and bit 2 clear pulses `init_req` for exactly one cycle. It makes bit 0 read 1 until `init_done` arrives. `init_done` sets the sticky init-done flag at bit 8.
- R4: `ev_in[i]` sets sticky bit 9+i. The mapping is index 0 transmit done, 1 receive done, 2 memory error, 3 missed frame, 4 collision, 5 babble. A command write with a 1 at a sticky position (bits 8..14) clears that bit. If an event arrives in the same cycle as the clear, the bit stays set.
- R5: A command write with bit 2 (stop) set overrides start, init and transmit demand in the same write. It clears `tx_on`, `rx_on`, the interrupt enable, all sticky bits and the running status bits, so the word reads 0x0004 afterwards.
- R6: A command write with bit 3 (transmit demand) set and bit 2 clear gives a one-cycle pulse on `tx_demand` in the following cycle. Bit 3 always reads 0.
- R7: Bit 7 reads as the OR of bits 9..14, together with bit 8 unless that bit is masked. `irq` equals bit 7 AND bit 6 (interrupt enable).
- R8: Bit 15 reads as the OR of bits 11..14: memory error, missed frame, collision and babble.
- R9: In the mask register (`reg_sel`=1), only bit 8 is stored, and the other bits read 0. Setting the mask removes init-done from bit 7 and `irq`, while bit 8 of the command word still reads 1.
- R10: Every command write without stop loads bit 6 from the written data. An acknowledge that also carries bit 6 therefore leaves interrupts enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| reg_sel | input | 1 | 0 selects the command word, 1 selects the mask register |
| wr_data | input | 16 | Host write data |
| rd_data | output | 16 | Read value of the selected register |
| init_done | input | 1 | Initialisation finished, one-cycle pulse |
| ev_in | input | 6 | Event pulses from the receive, transmit, memory and timing logic |
| irq | output | 1 | Interrupt request, active high |
| tx_on | output | 1 | Transmitter enabled |
| rx_on | output | 1 | Receiver enabled |
| init_req | output | 1 | One-cycle request to start initialisation |
| tx_demand | output | 1 | One-cycle request to poll the transmit ring |

## Verification
The sticky flags are swept over all 64 event patterns. After each pattern, an acknowledge mask derived from the pattern is applied. This separates a correct per-bit clear from a clear that touches neighbouring bits, and it shows whether the error summary and the interrupt flag follow the set of bits that remain. Directed cases cover the remaining behaviour:
- an event and its acknowledge in the same cycle, to show that set takes priority over clear;
- a masked init-done, which must stay visible yet raise no interrupt;
- an acknowledge with and without the enable bit;
- a stop written together with start and init, to confirm stop has priority.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int REG_W   = 16;
  localparam int NUM_EV  = 6;
  localparam int B_INIT  = 0;
  localparam int B_STRT  = 1;
  localparam int B_STOP  = 2;
  localparam int B_TDMD  = 3;
  localparam int B_TXON  = 4;
  localparam int B_RXON  = 5;
  localparam int B_IENA  = 6;
  localparam int B_INTR  = 7;
  localparam int B_IDON  = 8;
  localparam int B_ERR   = 15;
  localparam int STK_N   = NUM_EV + 1;      // init-done plus events
  localparam int STK_LSB = B_IDON;          // sticky field starts at init-done
  localparam int ERR_LO  = 3;               // sticky index of first error-class bit
  localparam int MASK_BIT = 8;              // mask bit position in mask register

  typedef struct packed {
    logic init;
    logic strt;
    logic stop;
    logic tdmd;
    logic iena;
  } cmd_t;

  function automatic cmd_t cmd_decode(input logic [REG_W-1:0] d);
    cmd_t c;
    c.init = d[B_INIT];
    c.strt = d[B_STRT];
    c.stop = d[B_STOP];
    c.tdmd = d[B_TDMD];
    c.iena = d[B_IENA];
    return c;
  endfunction
endpackage

// File: rtl/ccr_run_ctrl.sv
module ccr_run_ctrl
  import ccr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_wr,
  input  cmd_t cmd,
  input  logic init_done,
  output logic initing,
  output logic started,
  output logic stopped,
  output logic iena,
  output logic run_on,
  output logic init_req,
  output logic tx_demand
);
  logic stop_w;
  logic go_w;
  assign stop_w = cmd_wr & cmd.stop;
  assign go_w   = cmd_wr & ~cmd.stop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      initing   <= 1'b0;
      started   <= 1'b0;
      stopped   <= 1'b1;
      iena      <= 1'b0;
      run_on    <= 1'b0;
      init_req  <= 1'b0;
      tx_demand <= 1'b0;
    end else begin
      init_req  <= go_w & cmd.init;
      tx_demand <= go_w & cmd.tdmd;
      if (stop_w) begin
        initing <= 1'b0;
        started <= 1'b0;
        stopped <= 1'b1;
        iena    <= 1'b0;
        run_on  <= 1'b0;
      end else begin
        if (go_w) iena <= cmd.iena;
        if (go_w && cmd.init) begin
          initing <= 1'b1;
          stopped <= 1'b0;
        end else if (init_done) begin
          initing <= 1'b0;
        end
        if (go_w && cmd.strt) begin
          started <= 1'b1;
          stopped <= 1'b0;
          run_on  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ccr_sticky.sv
module ccr_sticky #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic         flush,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n || flush) q[i] <= 1'b0;
      else if (set[i])     q[i] <= 1'b1;
      else if (clr[i])     q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/ccr_irq_gen.sv
module ccr_irq_gen
  import ccr_pkg::*;
(
  input  logic [STK_N-1:0] sticky,
  input  logic             idon_mask,
  input  logic             iena,
  output logic             intr,
  output logic             err,
  output logic             irq
);
  logic [STK_N-1:0] gate;
  always_comb begin
    gate    = '1;
    gate[0] = ~idon_mask;
  end
  assign intr = |(sticky & gate);
  assign err  = |sticky[STK_N-1:ERR_LO];
  assign irq  = intr & iena;
endmodule

// File: rtl/ctrl_cmd_irq.sv
module ctrl_cmd_irq
  import ccr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              reg_sel,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic              init_done,
  input  logic [NUM_EV-1:0] ev_in,
  output logic              irq,
  output logic              tx_on,
  output logic              rx_on,
  output logic              init_req,
  output logic              tx_demand
);
  logic             cmd_wr, mask_wr;
  cmd_t             cmd;
  logic             initing, started, stopped, iena_q, run_on;
  logic             idon_mask_q;
  logic [STK_N-1:0] sticky_q, stk_clr;
  logic             intr, err;
  logic             unused_wr_bits;

  assign cmd_wr  = wr_en & ~reg_sel;
  assign mask_wr = wr_en & reg_sel;
  assign cmd     = cmd_decode(wr_data);
  assign stk_clr = cmd_wr ? wr_data[STK_LSB +: STK_N] : '0;
  assign unused_wr_bits = ^{wr_data[B_ERR], wr_data[B_INTR], wr_data[B_RXON], wr_data[B_TXON]};

  always_ff @(posedge clk) begin
    if (!rst_n)       idon_mask_q <= 1'b0;
    else if (mask_wr) idon_mask_q <= wr_data[MASK_BIT];
  end

  ccr_run_ctrl u_run (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd(cmd), .init_done(init_done),
    .initing(initing), .started(started), .stopped(stopped), .iena(iena_q),
    .run_on(run_on), .init_req(init_req), .tx_demand(tx_demand)
  );

  ccr_sticky #(.N(STK_N)) u_stk (
    .clk(clk), .rst_n(rst_n), .set({ev_in, init_done}), .clr(stk_clr),
    .flush(cmd_wr & cmd.stop), .q(sticky_q)
  );

  ccr_irq_gen u_irq (
    .sticky(sticky_q), .idon_mask(idon_mask_q), .iena(iena_q),
    .intr(intr), .err(err), .irq(irq)
  );

  assign tx_on = run_on;
  assign rx_on = run_on;

  always_comb begin
    rd_data = '0;
    if (reg_sel) begin
      rd_data[MASK_BIT] = idon_mask_q;
    end else begin
      rd_data[B_INIT] = initing;
      rd_data[B_STRT] = started;
      rd_data[B_STOP] = stopped;
      rd_data[B_TXON] = run_on;
      rd_data[B_RXON] = run_on;
      rd_data[B_IENA] = iena_q;
      rd_data[B_INTR] = intr;
      rd_data[STK_LSB +: STK_N] = sticky_q;
      rd_data[B_ERR]  = err;
    end
  end
endmodule

// File: rtl/ctrl_cmd_irq_chk.sv
module ctrl_cmd_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       reg_sel,
  input logic [3:0] wr_lo,
  input logic [5:0] ev_in,
  input logic       init_done,
  input logic       irq,
  input logic       tx_on,
  input logic       rx_on,
  input logic       tx_demand,
  input logic       init_req,
  input logic [6:0] sticky,
  input logic       iena
);
  logic stop_w;
  assign stop_w = wr_en && !reg_sel && wr_lo[2];

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_sel && wr_lo[1] && !wr_lo[2]) |=> (tx_on && rx_on));
  assert_init_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |-> $past(wr_en && !reg_sel && wr_lo[0] && !wr_lo[2]));
  assert_idon_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !stop_w) |=> sticky[0]);
  assert_event_sticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_in != 6'd0 && !stop_w) |=> ((sticky[6:1] & $past(ev_in)) == $past(ev_in)));
  assert_stop_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_w |=> (!tx_on && !rx_on && sticky == 7'd0 && !irq));
  assert_tdmd_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_demand |-> $past(wr_en && !reg_sel && wr_lo[3] && !wr_lo[2]));
  assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (iena && sticky != 7'd0));
endmodule

bind ctrl_cmd_irq ctrl_cmd_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel), .wr_lo(wr_data[3:0]),
  .ev_in(ev_in), .init_done(init_done), .irq(irq), .tx_on(tx_on), .rx_on(rx_on),
  .tx_demand(tx_demand), .init_req(init_req), .sticky(sticky_q), .iena(iena_q)
);

// File: tb/ctrl_cmd_irq_tb.sv
`timescale 1ns/1ps
module ctrl_cmd_irq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        reg_sel = 1'b0;
  logic [15:0] wr_data = 16'h0;
  logic [15:0] rd_data;
  logic        init_done = 1'b0;
  logic [5:0]  ev_in = 6'h0;
  logic        irq, tx_on, rx_on, init_req, tx_demand;
  int          total = 0;
  int          bad = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  ctrl_cmd_irq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel), .wr_data(wr_data),
    .rd_data(rd_data), .init_done(init_done), .ev_in(ev_in), .irq(irq),
    .tx_on(tx_on), .rx_on(rx_on), .init_req(init_req), .tx_demand(tx_demand)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic write(input logic sel, input logic [15:0] d);
    reg_sel = sel; wr_data = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0; wr_data = 16'h0; reg_sel = 1'b0;
  endtask

  task automatic read_cmd(input string req, input logic [15:0] exp);
    reg_sel = 1'b0;
    #0.1;
    check(req, rd_data, exp);
  endtask

  function automatic logic [15:0] expect_word(input logic [15:0] base, input logic [5:0] ev);
    logic [15:0] w;
    w = base | ({10'h0, ev} << 9);
    if (ev != 6'h0)          w = w | 16'h0080;
    if ((ev & 6'h3C) != 6'h0) w = w | 16'h8000;
    return w;
  endfunction

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got 0x0000 expected 0x0001");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    read_cmd("R1 reset word", 16'h0004);
    check("R1 irq", {15'h0, irq}, 16'h0);
    check("R1 tx_on", {15'h0, tx_on}, 16'h0);
    check("R1 pulses", {14'h0, init_req, tx_demand}, 16'h0);
    reg_sel = 1'b1; #0.1;
    check("R1 mask reg", rd_data, 16'h0000);

    // R3 init request and completion
    write(1'b0, 16'h0001);
    check("R3 init_req pulse", {15'h0, init_req}, 16'h1);
    read_cmd("R3 initialising", 16'h0001);
    step();
    check("R3 init_req one cycle", {15'h0, init_req}, 16'h0);
    init_done = 1'b1; step(); init_done = 1'b0;
    read_cmd("R3 init done", 16'h0180);
    check("R7 irq off without enable", {15'h0, irq}, 16'h0);

    // R9 mask register
    write(1'b1, 16'hFFFF);
    reg_sel = 1'b1; #0.1;
    check("R9 mask readback", rd_data, 16'h0100);
    read_cmd("R9 masked idon still visible", 16'h0100);

    // R2 start with enable
    write(1'b0, 16'h0042);
    read_cmd("R2 started", 16'h0172);
    check("R2 tx_on rx_on", {14'h0, tx_on, rx_on}, 16'h3);
    check("R9 masked idon no irq", {15'h0, irq}, 16'h0);

    // R10 acknowledge with enable kept
    write(1'b0, 16'h0140);
    read_cmd("R10 ack keeps enable", 16'h0072);
    write(1'b1, 16'h0000);

    // R4 R7 R8 sweep of all event patterns with derived clear masks
    for (int p = 0; p < 64; p++) begin
      logic [5:0] c, r;
      c = 6'((p * 37 + 11) & 63);
      r = 6'(p) & ~c;
      ev_in = 6'(p); step(); ev_in = 6'h0;
      read_cmd("R4 R8 event set", expect_word(16'h0072, 6'(p)));
      check("R7 irq after set", {15'h0, irq}, {15'h0, p != 0});
      write(1'b0, 16'h0040 | ({10'h0, c} << 9));
      read_cmd("R4 R8 partial clear", expect_word(16'h0072, r));
      check("R7 irq after clear", {15'h0, irq}, {15'h0, r != 6'h0});
      write(1'b0, 16'h7E40);
    end

    // R4 set beats clear in the same cycle
    ev_in = 6'h01; reg_sel = 1'b0; wr_data = 16'h0240; wr_en = 1'b1;
    step();
    wr_en = 1'b0; wr_data = 16'h0; ev_in = 6'h0;
    read_cmd("R4 set wins over clear", 16'h02F2);
    write(1'b0, 16'h0240);
    read_cmd("R4 cleared afterwards", 16'h0072);

    // R7 enable gating
    ev_in = 6'h02; step(); ev_in = 6'h0;
    write(1'b0, 16'h0000);
    read_cmd("R7 flag without enable", 16'h04B2);
    check("R7 irq gated", {15'h0, irq}, 16'h0);
    write(1'b0, 16'h0040);
    check("R7 irq enabled", {15'h0, irq}, 16'h1);

    // R6 transmit demand
    write(1'b0, 16'h0048);
    check("R6 tx_demand pulse", {15'h0, tx_demand}, 16'h1);
    read_cmd("R6 bit3 reads zero", 16'h04F2);
    step();
    check("R6 tx_demand one cycle", {15'h0, tx_demand}, 16'h0);

    // R5 stop wins over start, init and demand
    write(1'b0, 16'h000F);
    read_cmd("R5 stopped word", 16'h0004);
    check("R5 enables off", {13'h0, tx_on, rx_on, irq}, 16'h0);
    check("R5 no pulses", {14'h0, init_req, tx_demand}, 16'h0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule